// File: doc/BRIEF.md
# Gated Phase-Frequency Detector

This block compares a reference clock against one feedback tap of a delay line, with both signals already sampled into a fast system clock. It raises an UP request when the reference rises first and a DN request when the feedback rises first. When both requests are high, it holds them together for a fixed number of fast-clock cycles and then drops them both. This short overlap means that very small phase offsets still produce a correction, so the detector has no dead zone.

An enable input lets several detector and charge-pump pairs share a single reference, so the loop can move from one feedback tap to another without glitches. A disabled detector issues no requests. Enabling the detector does not take effect at once. The detector arms itself on the next reference rising edge, and any feedback edge that arrives before that point is discarded. Without this rule, the detector could be switched on between a reference edge and its matching feedback edge, see only half of the pair, and steer the loop into a false lock.

A signed accumulator adds one for each cycle in which only UP is high and subtracts one for each cycle in which only DN is high. This lets a test observe lead and lag polarity.

Top module: `gated_pfd`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `up` and `dn` go low, `phase_err` goes to zero, and the detector becomes disarmed.
- R2: A rising edge on an input means that the input is 1 in the current sample and was 0 in the previous sample. An input held high therefore gives only one edge.
- R3: When the detector is live, a reference rising edge sets `up` at the next clock edge, and a feedback rising edge sets `dn` at the next clock edge. Each one stays high until the detector clears.
- R4: When `up` and `dn` are both high, they stay high together for exactly `OVL_CYC` cycles (default 2) and then both clear at the same clock edge. Edges that arrive while both are high are dropped.
- R5: A rising edge of `enable` does not arm the detector. The detector arms on the first reference rising edge that is sampled while `enable` is high, and that edge also sets `up`. Feedback edges are ignored until the detector is armed, except for a feedback edge in the same sample as the arming edge.
- R6: While `enable` is low, `up` and `dn` are low from the next clock edge onward, whatever happens on `ref_in` and `fb_in`.
- R7: When `enable` falls, any active `up` or `dn` clears at the next clock edge and the detector disarms.
- R8: `phase_err` changes by +1 in each cycle where only `up` is high and by -1 in each cycle where only `dn` is high. It does not change when both are high or both are low.
- R9: A reference edge and a feedback edge in the same sample set `up` and `dn` at the same clock edge, followed by the overlap, and leave `phase_err` unchanged.
- R10: `phase_err` saturates at +(2^(ERR_W-1))-1 and at -(2^(ERR_W-1)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Switches this detector into the loop |
| ref_in | input | 1 | Sampled reference clock |
| fb_in | input | 1 | Sampled feedback tap |
| up | output | 1 | Request to lengthen the delay |
| dn | output | 1 | Request to shorten the delay |
| phase_err | output | ERR_W | Signed saturating UP-minus-DN cycle count |

## Verification
Two functions can land in the same cycle and must be separated. The first is an arming reference edge that coincides with a feedback edge. The second is a reference edge and a feedback edge that arrive in the same sample. In both cases `up` and `dn` must rise at the same clock edge and the accumulator must not move. The bench creates these cases by driving both inputs high in the same sample, both straight after an enable and once the detector is already armed. A behavioural model is compared against the design on every clock, and directed checks also confirm the overlap length and the zero net error.

// File: rtl/pfdg_pkg.sv
// Shared types for the gated phase-frequency detector.
// Assumes all inputs are already synchronous to the fast clock.
package pfdg_pkg;

    // Detector state: which of the two requests is currently raised.
    typedef enum logic [1:0] {
        PD_IDLE = 2'b00,
        PD_LEAD = 2'b01,
        PD_LAG  = 2'b10,
        PD_BOTH = 2'b11
    } pd_state_e;

    // Rising-edge strobes for the two compared inputs.
    typedef struct packed {
        logic fb_r;
        logic ref_r;
    } edge_pair_t;

endpackage

// File: rtl/pfdg_rise_det.sv
// Rising-edge detector for one sampled input.
// The output is high for the cycle in which the input reads 1
// after having read 0 in the previous sample. It assumes the input
// is synchronous to clk.
module pfdg_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic prev_q;

    // Keep the previous sample of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_in;
    end

    assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/pfdg_arm_gate.sv
// Arming gate. Once enable goes high, the gate waits for a reference
// rising edge before it lets edges through. It disarms as soon as
// enable is low. "live" is high while the detector may take edges,
// and that includes the arming edge itself.
module pfdg_arm_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ref_rise,
    output logic live
);
    logic armed_q;

    // Track the armed flag: set on the first reference edge, cleared when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (!enable) armed_q <= 1'b0;
        else if (ref_rise) armed_q <= 1'b1;
    end

    assign live = enable & (armed_q | ref_rise);
endmodule

// File: rtl/pfdg_core.sv
// Detector state machine that raises UP and DN. While both are raised it
// counts OVL_CYC cycles and then clears both together. A low enable clears
// everything at the next edge. It assumes OVL_CYC >= 1.
module pfdg_core
    import pfdg_pkg::*;
#(
    parameter int OVL_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       live,
    input  edge_pair_t edges,
    output logic       up,
    output logic       dn
);
    localparam int CNT_W = (OVL_CYC > 1) ? $clog2(OVL_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVL_CYC - 1);

    pd_state_e        state_q, state_d;
    logic [CNT_W-1:0] ovl_q, ovl_d;
    logic             take_ref, take_fb;

    assign take_ref = live & edges.ref_r;
    assign take_fb  = live & edges.fb_r;

    // Next-state logic for the request pair and the overlap counter.
    always_comb begin
        state_d = state_q;
        ovl_d   = ovl_q;
        if (!enable) begin
            state_d = PD_IDLE;
            ovl_d   = '0;
        end else begin
            unique case (state_q)
                PD_IDLE: begin
                    if (take_ref && take_fb) state_d = PD_BOTH;
                    else if (take_ref)       state_d = PD_LEAD;
                    else if (take_fb)        state_d = PD_LAG;
                end
                PD_LEAD: if (take_fb)  state_d = PD_BOTH;
                PD_LAG:  if (take_ref) state_d = PD_BOTH;
                PD_BOTH: begin
                    if (ovl_q == LAST) begin
                        state_d = PD_IDLE;
                        ovl_d   = '0;
                    end else begin
                        ovl_d = ovl_q + 1'b1;
                    end
                end
                default: state_d = PD_IDLE;
            endcase
        end
    end

    // Register the state and the overlap counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PD_IDLE;
            ovl_q   <= '0;
        end else begin
            state_q <= state_d;
            ovl_q   <= ovl_d;
        end
    end

    assign up = (state_q == PD_LEAD) | (state_q == PD_BOTH);
    assign dn = (state_q == PD_LAG)  | (state_q == PD_BOTH);
endmodule

// File: rtl/pfdg_err_acc.sv
// Signed saturating accumulator: adds 1 for each cycle with only UP high
// and subtracts 1 for each cycle with only DN high.
module pfdg_err_acc #(
    parameter int ERR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    up,
    input  logic                    dn,
    output logic signed [ERR_W-1:0] acc
);
    localparam logic signed [ERR_W-1:0] ACC_MAX = {1'b0, {(ERR_W-1){1'b1}}};
    localparam logic signed [ERR_W-1:0] ACC_MIN = {1'b1, {(ERR_W-1){1'b0}}};

    // Step the accumulator toward the request that is alone, and hold it at the limits.
    always_ff @(posedge clk) begin
        if (!rst_n)                             acc <= '0;
        else if (up && !dn && acc != ACC_MAX)   acc <= acc + 1'b1;
        else if (dn && !up && acc != ACC_MIN)   acc <= acc - 1'b1;
    end
endmodule

// File: rtl/gated_pfd.sv
// Top of the gated phase-frequency detector. Two rising-edge detectors
// feed an arming gate and the request state machine, and an accumulator
// tracks the signed request imbalance. All inputs are assumed to be
// sampled into clk already.
module gated_pfd
    import pfdg_pkg::*;
#(
    parameter int OVL_CYC = 2,
    parameter int ERR_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             ref_in,
    input  logic             fb_in,
    output logic             up,
    output logic             dn,
    output logic [ERR_W-1:0] phase_err
);
    localparam int NUM_IN = 2;

    logic [NUM_IN-1:0] raw_in, rise_vec;
    edge_pair_t        edges;
    logic              live;
    logic signed [ERR_W-1:0] acc;

    assign raw_in = {fb_in, ref_in};

    for (genvar i = 0; i < NUM_IN; i++) begin : g_rise
        pfdg_rise_det u_rise (
            .clk   (clk),
            .rst_n (rst_n),
            .sig_in(raw_in[i]),
            .rise  (rise_vec[i])
        );
    end

    assign edges.ref_r = rise_vec[0];
    assign edges.fb_r  = rise_vec[1];

    pfdg_arm_gate u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .ref_rise(edges.ref_r),
        .live    (live)
    );

    pfdg_core #(.OVL_CYC(OVL_CYC)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(enable),
        .live  (live),
        .edges (edges),
        .up    (up),
        .dn    (dn)
    );

    pfdg_err_acc #(.ERR_W(ERR_W)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .up   (up),
        .dn   (dn),
        .acc  (acc)
    );

    assign phase_err = acc;
endmodule

// File: rtl/gated_pfd_checker.sv
// Port-level properties of gated_pfd. Bound into every instance.
module gated_pfd_checker #(
    parameter int OVL_CYC = 2,
    parameter int ERR_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             ref_in,
    input logic             up,
    input logic             dn,
    input logic [ERR_W-1:0] phase_err
);
    localparam int RUN_W = $clog2(OVL_CYC + 2) + 1;
    logic [RUN_W-1:0] both_run;

    // Count consecutive cycles with both requests high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                          both_run <= '0;
        else if (!(up && dn))                both_run <= '0;
        else if (both_run <= RUN_W'(OVL_CYC)) both_run <= both_run + 1'b1;
    end

    // R4: the overlap never outlasts OVL_CYC cycles.
    a_r4_overlap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        both_run <= RUN_W'(OVL_CYC));

    // R4: from the overlap the two requests leave together.
    a_r4_clear_together: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> (up == dn));

    // R6: a low enable silences both requests at the next edge.
    a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!up && !dn));

    // R7: a falling enable clears any active request.
    a_r7_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enable) |=> (!up && !dn));

    // R3: a new UP follows a rising reference sample.
    a_r3_up_from_ref: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(up) && !$past(up && dn)) |-> ($past(ref_in) && !$past(ref_in, 2)));

    // R8: the accumulator never moves against a lone UP.
    a_r8_up_not_down: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !dn) |=> ($signed(phase_err) >= $signed($past(phase_err))));

    // R8: the accumulator holds while both requests are high.
    a_r8_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> $stable(phase_err));
endmodule

bind gated_pfd gated_pfd_checker #(.OVL_CYC(OVL_CYC), .ERR_W(ERR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .ref_in   (ref_in),
    .up       (up),
    .dn       (dn),
    .phase_err(phase_err)
);

// File: tb/gated_pfd_test.sv
module gated_pfd_test;
    localparam int OVL = 2;
    localparam int EW  = 16;
    localparam int EMAX = (1 << (EW - 1)) - 1;
    localparam int EMIN = -(1 << (EW - 1));

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, ref_in = 1'b0, fb_in = 1'b0;
    logic up, dn;
    logic [EW-1:0] phase_err;

    int errors = 0, checks = 0;
    bit done = 0;
    string cur_req = "R1";

    // Behavioural model state.
    int m_up = 0, m_dn = 0, m_run = 0, m_arm = 0, m_err = 0, m_rp = 0, m_fp = 0;

    gated_pfd #(.OVL_CYC(OVL), .ERR_W(EW)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ref_in(ref_in),
        .fb_in(fb_in), .up(up), .dn(dn), .phase_err(phase_err)
    );

    always #5 clk = ~clk;

    // Reference model: advance on each rising clock using the requirement rules.
    always @(posedge clk) begin
        int rr, fr, lv, nu, nd, nr;
        if (!rst_n) begin
            m_up = 0; m_dn = 0; m_run = 0; m_arm = 0; m_err = 0; m_rp = 0; m_fp = 0;
        end else begin
            rr = (ref_in && m_rp == 0) ? 1 : 0;
            fr = (fb_in && m_fp == 0) ? 1 : 0;
            lv = (enable && (m_arm == 1 || rr == 1)) ? 1 : 0;
            nu = m_up; nd = m_dn; nr = m_run;
            if (!enable) begin
                nu = 0; nd = 0; nr = 0;
            end else if (m_up == 1 && m_dn == 1) begin
                if (m_run == OVL - 1) begin nu = 0; nd = 0; nr = 0; end
                else nr = m_run + 1;
            end else begin
                if (lv == 1 && rr == 1) nu = 1;
                if (lv == 1 && fr == 1) nd = 1;
            end
            if (m_up == 1 && m_dn == 0 && m_err < EMAX) m_err = m_err + 1;
            else if (m_dn == 1 && m_up == 0 && m_err > EMIN) m_err = m_err - 1;
            m_arm = (enable && (m_arm == 1 || rr == 1)) ? 1 : 0;
            m_up = nu; m_dn = nd; m_run = nr;
            m_rp = ref_in ? 1 : 0; m_fp = fb_in ? 1 : 0;
        end
    end

    // Compare outputs with the model at every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (int'(up) != m_up || int'(dn) != m_dn || int'($signed(phase_err)) != m_err) begin
                errors++;
                $display("FAIL %s: up/dn/err act=%0d/%0d/%0d exp=%0d/%0d/%0d", cur_req,
                         up, dn, $signed(phase_err), m_up, m_dn, m_err);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic f);
        ref_in = r; fb_in = f;
        @(negedge clk);
    endtask

    function automatic int err_now();
        return int'($signed(phase_err));
    endfunction

    // One 16-cycle period: the leading input rises at 0, the other at gap.
    task automatic period(input bit ref_first, input int gap);
        for (int c = 0; c < 16; c++) begin
            logic a, b;
            a = (c < 3);
            b = (c >= gap && c < gap + 3);
            if (ref_first) step(a, b); else step(b, a);
        end
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: act=timeout exp=finish");
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base, seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 up", int'(up), 0);
        chk("R1 err", err_now(), 0);
        rst_n = 1'b1;
        step(0, 0);

        // R5: enable, then a feedback edge before arming is ignored.
        cur_req = "R5";
        enable = 1'b1;
        step(0, 0);
        step(0, 1); step(0, 1); step(0, 0);
        chk("R5 fb ignored before arming", int'(dn), 0);
        // R3/R2: reference edge sets up once, held input gives one edge.
        cur_req = "R3";
        step(1, 0);
        chk("R3 up set", int'(up), 1);
        step(1, 0); step(1, 0);
        chk("R2 held ref single edge", int'(dn), 0);
        // R4: overlap length then joint clear.
        cur_req = "R4";
        step(0, 1);
        chk("R4 both high 1", int'(up & dn), 1);
        step(0, 1);
        chk("R4 both high 2", int'(up & dn), 1);
        step(0, 0);
        chk("R4 both cleared", int'(up | dn), 0);
        repeat (4) step(0, 0);

        // R8: lead gives positive, lag gives negative error.
        cur_req = "R8";
        base = err_now();
        repeat (3) period(1, 4);
        chk("R8 lead +12", err_now() - base, 12);
        base = err_now();
        repeat (3) period(0, 5);
        chk("R8 lag -15", err_now() - base, -15);

        // R9: coincident edges while armed.
        cur_req = "R9";
        base = err_now();
        step(1, 1);
        chk("R9 same-cycle set", int'(up & dn), 1);
        repeat (15) step(0, 0);
        chk("R9 no net error", err_now() - base, 0);

        // R6: disabled detector ignores edges.
        cur_req = "R6";
        enable = 1'b0;
        seen = 0;
        for (int k = 0; k < 6; k++) begin
            step(1, 0); if (up || dn) seen = 1;
            step(0, 1); if (up || dn) seen = 1;
            step(0, 0); if (up || dn) seen = 1;
        end
        chk("R6 no pulses while off", seen, 0);

        // R5: arming edge coincident with feedback edge.
        cur_req = "R5";
        enable = 1'b1;
        step(0, 0);
        step(1, 1);
        chk("R5 arming edge with fb", int'(up & dn), 1);
        repeat (4) step(0, 0);

        // R7: drop enable with up active.
        cur_req = "R7";
        step(1, 0);
        chk("R7 up before drop", int'(up), 1);
        enable = 1'b0;
        step(0, 0);
        chk("R7 cleared on drop", int'(up | dn), 0);
        enable = 1'b1;
        step(0, 1); step(0, 0);
        chk("R7 disarmed after drop", int'(dn), 0);

        // R10: positive then negative saturation.
        cur_req = "R10";
        step(1, 0);
        repeat (33000) step(0, 0);
        chk("R10 max", err_now(), EMAX);
        step(0, 1); step(0, 0); step(0, 0);
        step(0, 1);
        chk("R10 dn alone", int'(dn & ~up), 1);
        repeat (66000) step(0, 0);
        chk("R10 min", err_now(), EMIN);
        step(1, 0);
        repeat (4) step(0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule